// File: doc/BRIEF.md
# Charger Operating Mode Controller

This block decides which operating mode a single-cell linear charger is in. It reads the supply comparators (undervoltage, input present, overvoltage), the host's active-low charge enable, the pack-temperature window, the die over-temperature comparator, the regulator-mode flag (timer pin left open) and the latched fault, termination and short-circuit flags that the detection circuits hold. From these it drives the power-stage enable, the clear and freeze controls of the charge timers, a flag telling the status pins when they may show real information, and a 3-bit mode code.

Standby and suspend both stop the power stage. Standby clears the timers. Suspend freezes them so charging picks up where it stopped once the pack is back in its temperature window. Two build-time parameters say whether the enable pin and the temperature pin exist. A missing pin is replaced by a fixed internal value: always enabled, and temperature always good. The power-on-reset wait is a parameter given in clock cycles.

Top module: `chg_mode_ctrl`

## Requirements
- R1: Whenever `uv_i` is high, the next mode is power-down (code 0). In power-down `pwr_en_o` and `stat_valid_o` are low and every other control input is ignored.
- R2: With `uv_i` low and `in_det_i` low, the next mode is sleep (code 1) from any mode. In sleep the power stage is off and the status outputs are not valid.
- R3: When input power is detected in power-down or sleep, the controller enters power-on-reset (code 2). It stays there for exactly `POR_CYCLES` clock cycles with `pwr_en_o` low, `stat_valid_o` low and `tmr_clr_o` high.
- R4: When power-on-reset ends, the controller goes to standby (code 3) if the charger is disabled (`en_n_i` high) or `ov_i` is high, and to begin-charge (code 4) otherwise. With `HAS_EN_PIN`=0 the charger always counts as enabled.
- R5: Begin-charge lasts one cycle with `tmr_clr_o` high and is followed by charge (code 5). `pwr_en_o` is high only in charge mode.
- R6: In charge mode a low `temp_ok_i` gives suspend (code 6). There the power stage is off, `tmr_hold_o` is high and `tmr_clr_o` is low (outside regulator mode). A good temperature returns the controller to charge mode.
- R7: With `HAS_TEMP_PIN`=0 the pack temperature counts as always good, so suspend is never entered.
- R8: `ov_i` high moves begin-charge, charge, suspend and halt to standby. Standby is left for begin-charge only when `ov_i` is low and the charger is enabled.
- R9: While `ldo_i` is high, `tmr_clr_o` is high and `tmr_hold_o` is low in every mode, and `term_i` has no effect.
- R10: While `tsd_i` is high, `pwr_en_o` is low in the same cycle, and the mode code does not change because of it.
- R11: In charge mode a set `tmr_fault_i` or `short_i`, or a set `term_i` outside regulator mode, gives halt (code 7) with the power stage off and `tmr_hold_o` high. This check takes priority over the temperature check. Halt is left only for standby or on loss of power.
- R12: `en_n_i` high moves begin-charge, charge, suspend and halt to standby (code 3). Standby clears the timers and keeps the power stage off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, to power-down |
| uv_i | input | 1 | Supply below undervoltage threshold |
| in_det_i | input | 1 | Input power detected |
| ov_i | input | 1 | Input overvoltage |
| en_n_i | input | 1 | Active-low charge enable |
| temp_ok_i | input | 1 | Pack temperature inside its window |
| tsd_i | input | 1 | Die over-temperature comparator |
| ldo_i | input | 1 | Regulator mode (timer pin open) |
| tmr_fault_i | input | 1 | Latched safety-timer fault |
| term_i | input | 1 | Latched termination |
| short_i | input | 1 | Latched output short circuit |
| pwr_en_o | output | 1 | Power stage enable |
| tmr_clr_o | output | 1 | Clear charge timers |
| tmr_hold_o | output | 1 | Freeze charge timers |
| stat_valid_o | output | 1 | Status outputs may show real state |
| mode_o | output | 3 | Current mode code |

## Verification
Every mode change is registered once. Inputs presented in a cycle therefore show up in `mode_o` and its derived outputs after the next rising edge, and power-on-reset ends `POR_CYCLES` edges after it starts. The die over-temperature input acts on `pwr_en_o` combinationally in the same cycle, without any edge. The bench changes inputs just after an edge, advances one edge, and then compares against a reference model stepped once per edge. Both parameter builds are swept with a long pseudo-random input stream.

// File: rtl/chg_mode_pkg.sv
// Package: mode encoding shared by the charger mode controller.
// Assumes a 3-bit mode code; values are visible on the mode output.
package chg_mode_pkg;
    typedef enum logic [2:0] {
        M_PDOWN   = 3'd0,
        M_SLEEP   = 3'd1,
        M_POR     = 3'd2,
        M_STBY    = 3'd3,
        M_BEGIN   = 3'd4,
        M_CHARGE  = 3'd5,
        M_SUSPEND = 3'd6,
        M_HALT    = 3'd7
    } chg_mode_e;
endpackage

// File: rtl/chg_in_cond.sv
// Input conditioning: replaces absent pins with fixed defaults and
// folds the latched stop flags, masking termination in regulator mode.
// Assumes all inputs are already synchronous to clk.
module chg_in_cond #(
    parameter bit HAS_EN_PIN   = 1'b1,
    parameter bit HAS_TEMP_PIN = 1'b1
) (
    input  logic en_n_i,
    input  logic temp_ok_i,
    input  logic ldo_i,
    input  logic tmr_fault_i,
    input  logic term_i,
    input  logic short_i,
    output logic enabled_o,
    output logic temp_good_o,
    output logic stop_o
);
    // Pick pin value or fixed default per build parameter.
    always_comb begin
        enabled_o   = HAS_EN_PIN   ? !en_n_i   : 1'b1;
        temp_good_o = HAS_TEMP_PIN ? temp_ok_i : 1'b1;
        stop_o      = tmr_fault_i || short_i || (term_i && !ldo_i);
    end
endmodule

// File: rtl/chg_por_timer.sv
// Power-on-reset wait counter: counts while the controller is in
// power-on-reset, flags the last cycle, clears itself otherwise.
// Assumes POR_CYCLES >= 1.
module chg_por_timer #(
    parameter int POR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);
    localparam int CW = $clog2(POR_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(POR_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent in power-on-reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (run_i && !done_o)   cnt_q <= cnt_q + 1'b1;
        else                         cnt_q <= '0;
    end

    // Last counted cycle of the wait.
    assign done_o = run_i && (cnt_q == LAST);

    // R3: counter never runs past the wait length
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/chg_mode_fsm.sv
// Mode state machine and output decode for the charger controller.
// Assumes conditioned enable/temperature/stop inputs from chg_in_cond
// and a wait-done pulse from chg_por_timer.
module chg_mode_fsm
    import chg_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_i,
    input  logic       in_det_i,
    input  logic       ov_i,
    input  logic       enabled_i,
    input  logic       temp_good_i,
    input  logic       stop_i,
    input  logic       tsd_i,
    input  logic       ldo_i,
    input  logic       por_done_i,
    output logic       por_run_o,
    output logic       pwr_en_o,
    output logic       tmr_clr_o,
    output logic       tmr_hold_o,
    output logic       stat_valid_o,
    output logic [2:0] mode_o
);
    chg_mode_e state_q, state_d;
    logic      go_stby;

    // Conditions that force standby once powered.
    assign go_stby = ov_i || !enabled_i;

    // Next-mode selection, supply conditions first.
    always_comb begin
        state_d = state_q;
        if (uv_i)           state_d = M_PDOWN;
        else if (!in_det_i) state_d = M_SLEEP;
        else begin
            case (state_q)
                M_PDOWN, M_SLEEP: state_d = M_POR;
                M_POR:     if (por_done_i) state_d = go_stby ? M_STBY : M_BEGIN;
                M_STBY:    if (!go_stby)   state_d = M_BEGIN;
                M_BEGIN:   state_d = go_stby ? M_STBY : M_CHARGE;
                M_CHARGE: begin
                    if (go_stby)           state_d = M_STBY;
                    else if (stop_i)       state_d = M_HALT;
                    else if (!temp_good_i) state_d = M_SUSPEND;
                end
                M_SUSPEND: begin
                    if (go_stby)           state_d = M_STBY;
                    else if (temp_good_i)  state_d = M_CHARGE;
                end
                M_HALT:    if (go_stby)    state_d = M_STBY;
                default:   state_d = M_PDOWN;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= M_PDOWN;
        else        state_q <= state_d;
    end

    // Output decode from the registered mode.
    always_comb begin
        por_run_o    = (state_q == M_POR);
        pwr_en_o     = (state_q == M_CHARGE) && !tsd_i;
        tmr_clr_o    = ldo_i || (state_q inside {M_PDOWN, M_SLEEP, M_POR, M_STBY, M_BEGIN});
        tmr_hold_o   = !ldo_i && (state_q inside {M_SUSPEND, M_HALT});
        stat_valid_o = !(state_q inside {M_PDOWN, M_SLEEP, M_POR});
        mode_o       = state_q;
    end

    // R1: undervoltage leads to power-down
    a_r1_pdown: assert property (@(posedge clk) disable iff (!rst_n)
        uv_i |=> (mode_o == M_PDOWN) && !pwr_en_o && !stat_valid_o);
    // R2: lost input leads to sleep
    a_r2_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (!uv_i && !in_det_i) |=> (mode_o == M_SLEEP));
    // R5: begin-charge lasts one cycle
    a_r5_begin_once: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_BEGIN) |=> (mode_o != M_BEGIN));
    // R6: suspend never powers the stage
    a_r6_susp_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_SUSPEND) |-> !pwr_en_o);
    // R8: overvoltage while charging leads to standby
    a_r8_ov_stby: assert property (@(posedge clk) disable iff (!rst_n)
        (!uv_i && in_det_i && ov_i && (mode_o inside {M_BEGIN, M_CHARGE, M_SUSPEND, M_HALT}))
        |=> (mode_o == M_STBY));
    // R10: die over-temperature blocks the stage
    a_r10_tsd_off: assert property (@(posedge clk) disable iff (!rst_n)
        tsd_i |-> !pwr_en_o);
    // R11: halt keeps the stage off
    a_r11_halt_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == M_HALT) |-> !pwr_en_o);
endmodule

// File: rtl/chg_mode_ctrl.sv
// Top of the charger mode controller: conditions inputs, times the
// power-on-reset wait and runs the mode state machine.
// Assumes synchronous inputs; POR_CYCLES >= 1.
module chg_mode_ctrl #(
    parameter bit HAS_EN_PIN   = 1'b1,
    parameter bit HAS_TEMP_PIN = 1'b1,
    parameter int POR_CYCLES   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uv_i,
    input  logic       in_det_i,
    input  logic       ov_i,
    input  logic       en_n_i,
    input  logic       temp_ok_i,
    input  logic       tsd_i,
    input  logic       ldo_i,
    input  logic       tmr_fault_i,
    input  logic       term_i,
    input  logic       short_i,
    output logic       pwr_en_o,
    output logic       tmr_clr_o,
    output logic       tmr_hold_o,
    output logic       stat_valid_o,
    output logic [2:0] mode_o
);
    logic enabled, temp_good, stop, por_run, por_done;

    chg_in_cond #(
        .HAS_EN_PIN   (HAS_EN_PIN),
        .HAS_TEMP_PIN (HAS_TEMP_PIN)
    ) cond_i (
        .en_n_i      (en_n_i),
        .temp_ok_i   (temp_ok_i),
        .ldo_i       (ldo_i),
        .tmr_fault_i (tmr_fault_i),
        .term_i      (term_i),
        .short_i     (short_i),
        .enabled_o   (enabled),
        .temp_good_o (temp_good),
        .stop_o      (stop)
    );

    chg_por_timer #(.POR_CYCLES(POR_CYCLES)) por_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (por_run),
        .done_o (por_done)
    );

    chg_mode_fsm fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .uv_i         (uv_i),
        .in_det_i     (in_det_i),
        .ov_i         (ov_i),
        .enabled_i    (enabled),
        .temp_good_i  (temp_good),
        .stop_i       (stop),
        .tsd_i        (tsd_i),
        .ldo_i        (ldo_i),
        .por_done_i   (por_done),
        .por_run_o    (por_run),
        .pwr_en_o     (pwr_en_o),
        .tmr_clr_o    (tmr_clr_o),
        .tmr_hold_o   (tmr_hold_o),
        .stat_valid_o (stat_valid_o),
        .mode_o       (mode_o)
    );
endmodule

// File: tb/chg_mode_ctrl_tb.sv
// Bench: directed sequences plus a long pseudo-random sweep on two
// builds (all pins / no optional pins) against a reference model.
module chg_mode_ctrl_tb_top;
    localparam int P = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uv = 1'b1, det = 1'b0, ov = 1'b0, en_n = 1'b0, tok = 1'b1;
    logic tsd = 1'b0, ldo = 1'b0, flt = 1'b0, term = 1'b0, sc = 1'b0;
    logic       pe_a, clr_a, hold_a, sv_a;
    logic [2:0] md_a;
    logic       pe_b, clr_b, hold_b, sv_b;
    logic [2:0] md_b;
    int errors = 0, checks = 0;
    int m_a = 0, c_a = 0, m_b = 0, c_b = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    chg_mode_ctrl #(.HAS_EN_PIN(1), .HAS_TEMP_PIN(1), .POR_CYCLES(P)) dut_i (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .in_det_i(det), .ov_i(ov),
        .en_n_i(en_n), .temp_ok_i(tok), .tsd_i(tsd), .ldo_i(ldo),
        .tmr_fault_i(flt), .term_i(term), .short_i(sc),
        .pwr_en_o(pe_a), .tmr_clr_o(clr_a), .tmr_hold_o(hold_a),
        .stat_valid_o(sv_a), .mode_o(md_a));

    chg_mode_ctrl #(.HAS_EN_PIN(0), .HAS_TEMP_PIN(0), .POR_CYCLES(P)) dut_nopin_i (
        .clk(clk), .rst_n(rst_n), .uv_i(uv), .in_det_i(det), .ov_i(ov),
        .en_n_i(en_n), .temp_ok_i(tok), .tsd_i(tsd), .ldo_i(ldo),
        .tmr_fault_i(flt), .term_i(term), .short_i(sc),
        .pwr_en_o(pe_b), .tmr_clr_o(clr_b), .tmr_hold_o(hold_b),
        .stat_valid_o(sv_b), .mode_o(md_b));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic string req_of(input int m);
        case (m)
            0: return "R1";  1: return "R2";  2: return "R3";  3: return "R12";
            4: return "R4";  5: return "R5";  6: return "R6";  default: return "R11";
        endcase
    endfunction

    // Reference next mode from the requirements.
    function automatic int nxt(input int m, input int c, input bit has_en, input bit has_t);
        bit en  = has_en ? !en_n : 1'b1;
        bit tg  = has_t ? tok : 1'b1;
        bit stp = flt || sc || (term && !ldo);
        bit gs  = ov || !en;
        if (uv) return 0;
        if (!det) return 1;
        case (m)
            0, 1: return 2;
            2: return (c == P - 1) ? (gs ? 3 : 4) : 2;
            3: return gs ? 3 : 4;
            4: return gs ? 3 : 5;
            5: return gs ? 3 : (stp ? 7 : (!tg ? 6 : 5));
            6: return gs ? 3 : (tg ? 5 : 6);
            default: return gs ? 3 : 7;
        endcase
    endfunction

    task automatic cmp(input int m, input logic [2:0] md, input logic pe,
                       input logic clr, input logic hold, input logic sv);
        string r = req_of(m);
        bit epe = (m == 5) && !tsd;
        bit eclr = ldo || (m <= 4);
        bit ehold = !ldo && (m >= 6);
        bit esv = (m >= 3);
        chk(md == 3'(m), r, md, m);
        chk(pe == epe, tsd ? "R10" : r, pe, epe);
        chk(clr == eclr, ldo ? "R9" : r, clr, eclr);
        chk(hold == ehold, ldo ? "R9" : r, hold, ehold);
        chk(sv == esv, r, sv, esv);
    endtask

    // One edge: step both models, then compare both builds.
    task automatic step();
        int na = nxt(m_a, c_a, 1'b1, 1'b1);
        int nb = nxt(m_b, c_b, 1'b0, 1'b0);
        int ca = (m_a == 2 && c_a != P - 1) ? c_a + 1 : 0;
        int cb = (m_b == 2 && c_b != P - 1) ? c_b + 1 : 0;
        @(posedge clk); #1;
        m_a = na; c_a = ca; m_b = nb; c_b = cb;
        cmp(m_a, md_a, pe_a, clr_a, hold_a, sv_a);
        cmp(m_b, md_b, pe_b, clr_b, hold_b, sv_b);
    endtask

    initial begin : watchdog
        #1_500_000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        uint_loop();
    end

    task automatic uint_loop();
        logic [31:0] r = 32'h1234_5678;
        int por_len = 0;
        repeat (3) @(posedge clk);
        #1;
        // Reset state: power-down, stage off, status not valid (R1)
        chk(md_a == 3'd0 && !pe_a && !sv_a && clr_a, "R1", md_a, 0);
        rst_n = 1'b1;
        // R1: control inputs ignored under undervoltage
        en_n = 1'b0; det = 1'b1; step();
        chk(md_a == 3'd0, "R1", md_a, 0);
        // R2: sleep when input is missing
        uv = 1'b0; det = 1'b0; step();
        chk(md_a == 3'd1, "R2", md_a, 1);
        // R3: power-on-reset lasts P cycles
        det = 1'b1;
        do begin step(); por_len++; end while (md_a == 3'd2 && por_len < 50);
        chk(por_len - 1 == P, "R3", por_len - 1, P);
        // R4 and R5: begin-charge for one cycle, then charge
        chk(md_a == 3'd4, "R4", md_a, 4);
        step(); chk(md_a == 3'd5 && pe_a, "R5", md_a, 5);
        // R7: no-pin build ignores temperature; pinned build suspends (R6)
        tok = 1'b0; step();
        chk(md_a == 3'd6 && hold_a && !clr_a && !pe_a, "R6", md_a, 6);
        chk(md_b == 3'd5, "R7", md_b, 5);
        tok = 1'b1; step(); chk(md_a == 3'd5, "R6", md_a, 5);
        // R10: over-temperature drops the stage at once, mode kept
        tsd = 1'b1; #1; chk(!pe_a, "R10", pe_a, 0);
        step(); chk(md_a == 3'd5, "R10", md_a, 5);
        tsd = 1'b0;
        // R9: termination ignored in regulator mode
        ldo = 1'b1; term = 1'b1; step();
        chk(md_a == 3'd5 && clr_a && !hold_a, "R9", md_a, 5);
        // R11: termination outside regulator mode halts, beats temperature
        ldo = 1'b0; tok = 1'b0; step();
        chk(md_a == 3'd7 && hold_a && !pe_a, "R11", md_a, 7);
        term = 1'b0; tok = 1'b1; step(); chk(md_a == 3'd7, "R11", md_a, 7);
        // R8: overvoltage to standby, leave once cleared
        ov = 1'b1; step(); chk(md_a == 3'd3 && clr_a, "R8", md_a, 3);
        ov = 1'b0; step(); chk(md_a == 3'd4, "R8", md_a, 4);
        step();
        // R12: disable leads to standby; no-pin build keeps charging (R4)
        en_n = 1'b1; step();
        chk(md_a == 3'd3 && !pe_a, "R12", md_a, 3);
        chk(md_b == 3'd5, "R4", md_b, 5);
        en_n = 1'b0;
        // Pseudo-random sweep over all inputs
        for (int i = 0; i < 6000; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            uv   = (r[4:0] == 5'd0);
            det  = (r[9:5] != 5'd0);
            ov   = (r[12:10] == 3'd0);
            en_n = (r[15:13] == 3'd0);
            tok  = (r[18:16] != 3'd0);
            tsd  = (r[21:19] == 3'd0);
            ldo  = (r[23:22] == 2'd0);
            flt  = (r[27:24] == 4'd0);
            term = (r[30:28] == 3'd0);
            sc   = (r[31] && r[0] && r[1] && r[2]);
            step();
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask
endmodule